// File: doc/BRIEF.md
# IDE Task-File Window with Hidden Configuration Registers

This block sits on the task-file I/O window of one IDE channel, between the host-side register port and the drive-side register port. While the window is locked, every access goes straight through to the drive: the request, direction, width, offset and write data are forwarded unchanged, and read data comes back from the drive.

A fixed pattern of accesses on the drive's own ports opens a hidden configuration space. The pattern is two 16-bit reads of the error register (offset 1) followed by a byte write of 0x03 to offset 2. Once the window is open, nothing reaches the drive. Byte writes at small offsets then program per-device read-cycle and write-cycle timing, a device-select and address-setup byte, a control byte that switches the programmed timings in over the strapped defaults, and a probe for the bus-clock strap. A byte write of 0x83 to offset 2 closes the window again.

The timing bytes are broken into an active-time nibble and a recovery-time nibble for each device. These nibbles, the shared address-setup field and the override flag are the outputs that the strobe generator consumes.

Top module: `ide_cfg_gate`

## Requirements
- R1: After reset the window is locked (`cfg_mode` = 0) and `timing_override` = 0. Every timing byte reads as 0xFF, so every active and recovery nibble is 0xF. The misc byte is 0x30, so `addr_setup` = 3 and device 0 is selected.
- R2: While locked, every host access is forwarded in the same cycle. `drv_req`, `drv_wr`, `drv_wide`, `drv_ofs` and `drv_wdata` equal their host counterparts, and `host_rdata` equals `drv_rdata`. This holds for the accesses of the opening pattern as well.
- R3: While locked, two 16-bit reads (`host_wide` = 1, `host_wr` = 0) at offset 1 that are the two most recent accesses, followed by a byte write (`host_wide` = 0) of 0x03 to offset 2, open the window from the next clock on. Cycles with `host_req` = 0 between these accesses do not break the pattern. More than two such reads in a row still count as two.
- R4: Any access other than the next expected step clears the progress of the pattern. Such an access is a byte read at offset 1, any access at another offset, or a write to offset 2 of any value other than 0x03. After such an access a following 0x03 write does not open the window.
- R5: While the window is open, `drv_req` stays 0 for every access.
- R6: While open, a byte write to offset 6 loads the misc byte. Bit 0 of that byte selects the device (0 or 1) that later timing writes target and that timing readback shows. Bits 5:4 of the byte are `addr_setup`, which both devices share. Reading offset 6 returns the byte in `host_rdata[7:0]`, with the upper bits 0.
- R7: While open, a byte write to offset 0 loads the selected device's read-cycle timing byte, and a byte write to offset 1 loads its write-cycle timing byte. For device d, bits 7:4 of these bytes appear on `rd_active[4d+3:4d]` and `wr_active`, and bits 3:0 appear on `rd_recover` and `wr_recover`. Reading offsets 0 and 1 returns the selected device's bytes.
- R8: While open, a byte write of 0x85 to offset 3 sets `timing_override`, and a byte write of any other value clears it. Reading offset 3 returns the last byte written there.
- R9: While open, reading offset 5 returns the clock strap input `clk_strap` in bit 0, with every other bit 0. This holds only if the last byte written to offset 5 was 0xFF; before such a write, or after any other value is written there, the read returns 0.
- R10: While open, a byte write of 0x83 to offset 2 locks the window from the next clock. Any other value written to offset 2 leaves it open.
- R11: While locked, no access changes the timing bytes, the misc byte or the control byte.
- R12: While open, 16-bit writes change no internal register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_ofs | input | 3 | Register offset within the task-file window |
| host_wdata | input | 16 | Host write data (byte accesses use bits 7:0) |
| host_rdata | output | 16 | Read data returned to the host |
| drv_req | output | 1 | Forwarded access valid |
| drv_wr | output | 1 | Forwarded direction |
| drv_wide | output | 1 | Forwarded width |
| drv_ofs | output | 3 | Forwarded offset |
| drv_wdata | output | 16 | Forwarded write data |
| drv_rdata | input | 16 | Read data from the drive task file |
| clk_strap | input | 1 | Bus-clock-speed strap |
| cfg_mode | output | 1 | 1 while the configuration window is open |
| rd_active | output | 8 | Read active-time nibble, 4 bits per device |
| rd_recover | output | 8 | Read recovery-time nibble, 4 bits per device |
| wr_active | output | 8 | Write active-time nibble, 4 bits per device |
| wr_recover | output | 8 | Write recovery-time nibble, 4 bits per device |
| addr_setup | output | 2 | Shared address-setup field |
| timing_override | output | 1 | Programmed timings replace the strapped defaults |

## Verification
The assertions take as given that the host holds `host_req` low during reset. They also assume that each access occupies one clock, so the two reads and the key write of an opening pattern can be matched over consecutive cycles with `$past`. The stimulus drives one access per cycle, changed a short time after each rising edge, and keeps `host_req` low in reset and in idle cycles. It runs some patterns back to back and some with idle gaps, so both the strict consecutive form and the gapped form of R3 are exercised.

// File: rtl/ide_gate_pkg.sv
package ide_gate_pkg;

    localparam int OFS_W  = 3;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    // Offsets decoded by the gate and the configuration bank
    localparam logic [OFS_W-1:0] OFS_RDTIM = 3'd0;
    localparam logic [OFS_W-1:0] OFS_WRTIM = 3'd1;
    localparam logic [OFS_W-1:0] OFS_ERR   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_GATE  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd3;
    localparam logic [OFS_W-1:0] OFS_STRAP = 3'd5;
    localparam logic [OFS_W-1:0] OFS_MISC  = 3'd6;

    localparam logic [BYTE_W-1:0] KEY_OPEN    = 8'h03;
    localparam logic [BYTE_W-1:0] KEY_CLOSE   = 8'h83;
    localparam logic [BYTE_W-1:0] CTRL_OVR    = 8'h85;
    localparam logic [BYTE_W-1:0] STRAP_PROBE = 8'hFF;

    typedef enum logic [1:0] {
        ARM_NONE = 2'd0,
        ARM_ONE  = 2'd1,
        ARM_TWO  = 2'd2
    } arm_t;

    typedef struct packed {
        logic              req;
        logic              wr;
        logic              wide;
        logic [OFS_W-1:0]  ofs;
        logic [BYTE_W-1:0] wbyte;
    } hacc_t;

    function automatic logic is_err_wide_read(hacc_t a);
        return a.req && !a.wr && a.wide && (a.ofs == OFS_ERR);
    endfunction

    function automatic logic is_byte_write(hacc_t a, logic [OFS_W-1:0] o,
                                           logic [BYTE_W-1:0] v);
        return a.req && a.wr && !a.wide && (a.ofs == o) && (a.wbyte == v);
    endfunction

endpackage

// File: rtl/ide_gate_seq.sv
module ide_gate_seq
    import ide_gate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hacc_t acc,
    output logic  cfg_mode
);

    arm_t arm_q;
    arm_t arm_d;
    logic open_q;
    logic open_d;

    always_comb begin
        arm_d  = arm_q;
        open_d = open_q;
        if (acc.req) begin
            if (!open_q) begin
                if (is_err_wide_read(acc)) begin
                    arm_d = (arm_q == ARM_NONE) ? ARM_ONE : ARM_TWO;
                end else if ((arm_q == ARM_TWO) &&
                             is_byte_write(acc, OFS_GATE, KEY_OPEN)) begin
                    arm_d  = ARM_NONE;
                    open_d = 1'b1;
                end else begin
                    arm_d = ARM_NONE;
                end
            end else begin
                arm_d = ARM_NONE;
                if (is_byte_write(acc, OFS_GATE, KEY_CLOSE)) begin
                    open_d = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= ARM_NONE;
            open_q <= 1'b0;
        end else begin
            arm_q  <= arm_d;
            open_q <= open_d;
        end
    end

    assign cfg_mode = open_q;

endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
    import ide_gate_pkg::*;
#(
    parameter int                NDEV        = 2,
    parameter logic [BYTE_W-1:0] DEF_TIMING  = 8'hFF,
    parameter logic [BYTE_W-1:0] DEF_MISC    = 8'h30
) (
    input  logic                     clk,
    input  logic                     rst,
    input  hacc_t                    acc,
    input  logic                     cfg_mode,
    input  logic                     strap_in,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NDEV*BYTE_W-1:0]   rd_tim,
    output logic [NDEV*BYTE_W-1:0]   wr_tim,
    output logic [1:0]               addr_setup,
    output logic                     override
);

    localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1;

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] misc_q;
    logic              probe_q;
    logic              wr_en;
    logic [SEL_W-1:0]  dev_sel;
    logic [BYTE_W-1:0] rt_q [NDEV];
    logic [BYTE_W-1:0] wt_q [NDEV];
    logic [BYTE_W-1:0] rd_byte;

    assign wr_en   = cfg_mode && acc.req && acc.wr && !acc.wide;
    assign dev_sel = misc_q[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            misc_q  <= DEF_MISC;
            probe_q <= 1'b0;
        end else if (wr_en) begin
            case (acc.ofs)
                OFS_CTRL:  ctrl_q  <= acc.wbyte;
                OFS_MISC:  misc_q  <= acc.wbyte;
                OFS_STRAP: probe_q <= (acc.wbyte == STRAP_PROBE);
                default: ;
            endcase
        end
    end

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        always_ff @(posedge clk) begin
            if (rst) begin
                rt_q[d] <= DEF_TIMING;
                wt_q[d] <= DEF_TIMING;
            end else if (wr_en && (dev_sel == SEL_W'(d))) begin
                if (acc.ofs == OFS_RDTIM) rt_q[d] <= acc.wbyte;
                if (acc.ofs == OFS_WRTIM) wt_q[d] <= acc.wbyte;
            end
        end
        assign rd_tim[d*BYTE_W +: BYTE_W] = rt_q[d];
        assign wr_tim[d*BYTE_W +: BYTE_W] = wt_q[d];
    end

    always_comb begin
        case (acc.ofs)
            OFS_RDTIM: rd_byte = rt_q[dev_sel];
            OFS_WRTIM: rd_byte = wt_q[dev_sel];
            OFS_CTRL:  rd_byte = ctrl_q;
            OFS_STRAP: rd_byte = {{(BYTE_W-1){1'b0}}, probe_q & strap_in};
            OFS_MISC:  rd_byte = misc_q;
            default:   rd_byte = '0;
        endcase
    end

    assign rd_data    = {{(DATA_W-BYTE_W){1'b0}}, rd_byte};
    assign addr_setup = misc_q[5:4];
    assign override   = (ctrl_q == CTRL_OVR);

endmodule

// File: rtl/ide_cfg_gate.sv
module ide_cfg_gate
    import ide_gate_pkg::*;
#(
    parameter int NDEV = 2,
    localparam int NIB_W = NDEV * 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic              host_wide,
    input  logic [2:0]        host_ofs,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              drv_req,
    output logic              drv_wr,
    output logic              drv_wide,
    output logic [2:0]        drv_ofs,
    output logic [15:0]       drv_wdata,
    input  logic [15:0]       drv_rdata,
    input  logic              clk_strap,
    output logic              cfg_mode,
    output logic [NIB_W-1:0]  rd_active,
    output logic [NIB_W-1:0]  rd_recover,
    output logic [NIB_W-1:0]  wr_active,
    output logic [NIB_W-1:0]  wr_recover,
    output logic [1:0]        addr_setup,
    output logic              timing_override
);

    hacc_t                     acc;
    logic [DATA_W-1:0]         cfg_rdata;
    logic [NDEV*BYTE_W-1:0]    rd_tim;
    logic [NDEV*BYTE_W-1:0]    wr_tim;

    assign acc = '{req: host_req, wr: host_wr, wide: host_wide,
                   ofs: host_ofs, wbyte: host_wdata[BYTE_W-1:0]};

    ide_gate_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .cfg_mode (cfg_mode)
    );

    ide_cfg_regs #(.NDEV(NDEV)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .cfg_mode   (cfg_mode),
        .strap_in   (clk_strap),
        .rd_data    (cfg_rdata),
        .rd_tim     (rd_tim),
        .wr_tim     (wr_tim),
        .addr_setup (addr_setup),
        .override   (timing_override)
    );

    for (genvar d = 0; d < NDEV; d++) begin : g_nib
        assign rd_active [d*4 +: 4] = rd_tim[d*BYTE_W+4 +: 4];
        assign rd_recover[d*4 +: 4] = rd_tim[d*BYTE_W   +: 4];
        assign wr_active [d*4 +: 4] = wr_tim[d*BYTE_W+4 +: 4];
        assign wr_recover[d*4 +: 4] = wr_tim[d*BYTE_W   +: 4];
    end

    assign drv_req    = host_req && !cfg_mode;
    assign drv_wr     = host_wr;
    assign drv_wide   = host_wide;
    assign drv_ofs    = host_ofs;
    assign drv_wdata  = host_wdata;
    assign host_rdata = cfg_mode ? cfg_rdata : drv_rdata;

endmodule

// File: rtl/ide_cfg_gate_chk.sv
module ide_cfg_gate_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_req,
    input logic        host_wr,
    input logic        host_wide,
    input logic [2:0]  host_ofs,
    input logic [15:0] host_wdata,
    input logic        drv_req,
    input logic        cfg_mode,
    input logic [7:0]  rd_active,
    input logic [7:0]  rd_recover,
    input logic [7:0]  wr_active,
    input logic [7:0]  wr_recover,
    input logic [1:0]  addr_setup,
    input logic        timing_override
);

    logic err_rd;
    logic key_open;
    logic key_close;

    assign err_rd    = host_req && !host_wr && host_wide && (host_ofs == 3'd1);
    assign key_open  = host_req && host_wr && !host_wide && (host_ofs == 3'd2)
                       && (host_wdata[7:0] == 8'h03);
    assign key_close = host_req && host_wr && !host_wide && (host_ofs == 3'd2)
                       && (host_wdata[7:0] == 8'h83);

    // R1: reset leaves the window locked and override off
    a_r1_reset_locked: assert property (@(posedge clk)
        rst |=> (!cfg_mode && !timing_override));

    // R3: consecutive read, read, key write opens the window
    a_r3_key_opens: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && key_open && $past(err_rd) && $past(err_rd, 2)) |=> cfg_mode);

    // R3/R4: the window only opens right after a key write
    a_r4_open_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_mode) |-> $past(key_open));

    // R5: nothing reaches the drive while open
    a_r5_no_forward: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> !drv_req);

    // R10: close key locks the window
    a_r10_close_key: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && key_close) |=> !cfg_mode);

    // R10: the window only closes on a close key
    a_r10_close_needs_key: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_mode) |-> $past(key_close));

    // R11: locked accesses leave the programmed state alone
    a_r11_locked_stable: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> ($stable(rd_active) && $stable(rd_recover) &&
                       $stable(wr_active) && $stable(wr_recover) &&
                       $stable(addr_setup) && $stable(timing_override)));

endmodule

bind ide_cfg_gate ide_cfg_gate_chk chk_i (
    .clk             (clk),
    .rst             (rst),
    .host_req        (host_req),
    .host_wr         (host_wr),
    .host_wide       (host_wide),
    .host_ofs        (host_ofs),
    .host_wdata      (host_wdata),
    .drv_req         (drv_req),
    .cfg_mode        (cfg_mode),
    .rd_active       (rd_active),
    .rd_recover      (rd_recover),
    .wr_active       (wr_active),
    .wr_recover      (wr_recover),
    .addr_setup      (addr_setup),
    .timing_override (timing_override)
);

// File: tb/ide_cfg_gate_tb.sv
module ide_cfg_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_wide = 1'b0;
    logic [2:0]  host_ofs = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        drv_req, drv_wr, drv_wide;
    logic [2:0]  drv_ofs;
    logic [15:0] drv_wdata;
    logic [15:0] drv_rdata;
    logic        clk_strap = 1'b0;
    logic        cfg_mode;
    logic [7:0]  rd_active, rd_recover, wr_active, wr_recover;
    logic [1:0]  addr_setup;
    logic        timing_override;

    always #10 clk = ~clk;

    assign drv_rdata = 16'hC0D0 | {13'b0, drv_ofs};

    ide_cfg_gate dut_i (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_wr(host_wr), .host_wide(host_wide),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .drv_req(drv_req), .drv_wr(drv_wr), .drv_wide(drv_wide),
        .drv_ofs(drv_ofs), .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
        .clk_strap(clk_strap), .cfg_mode(cfg_mode),
        .rd_active(rd_active), .rd_recover(rd_recover),
        .wr_active(wr_active), .wr_recover(wr_recover),
        .addr_setup(addr_setup), .timing_override(timing_override)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data when a read is on the port
    always @(negedge clk) begin : mon
        logic [15:0] e;
        string       t;
        if (!rst && host_req && !host_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", 32'(host_rdata), 32'h0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(host_rdata == e, t, 32'(host_rdata), 32'(e));
            end
        end
    end

    // Driver: one access per cycle; fwd = expect forwarding to the drive
    task automatic acc(input bit wr, input bit wide, input logic [2:0] ofs,
                       input logic [15:0] d, input bit fwd,
                       input logic [15:0] exp_rd, input string tag);
        @(posedge clk);
        #2;
        host_req   = 1'b1;
        host_wr    = wr;
        host_wide  = wide;
        host_ofs   = ofs;
        host_wdata = d;
        if (!wr) begin
            exp_q.push_back(exp_rd);
            tag_q.push_back(tag);
        end
        #1;
        if (fwd)
            chk(drv_req && drv_wr == wr && drv_wide == wide && drv_ofs == ofs
                && drv_wdata == d, "R2 forwarded fields",
                {drv_req, drv_wr, drv_wide, drv_ofs, 10'b0, drv_wdata},
                {1'b1, wr, wide, ofs, 10'b0, d});
        else
            chk(!drv_req, "R5 no forward while open", 32'(drv_req), 32'h0);
    endtask

    task automatic idle();
        @(posedge clk);
        #2;
        host_req = 1'b0;
        host_wr  = 1'b0;
    endtask

    task automatic lrd(input logic [2:0] ofs, input bit wide);
        acc(1'b0, wide, ofs, 16'h0, 1'b1, 16'hC0D0 | {13'b0, ofs}, "R2 read data");
    endtask

    task automatic lwr(input logic [2:0] ofs, input logic [7:0] b);
        acc(1'b1, 1'b0, ofs, {8'h5A, b}, 1'b1, 16'h0, "");
    endtask

    task automatic cwr(input logic [2:0] ofs, input logic [7:0] b);
        acc(1'b1, 1'b0, ofs, {8'hA5, b}, 1'b0, 16'h0, "");
    endtask

    task automatic crd(input logic [2:0] ofs, input logic [15:0] e, input string tag);
        acc(1'b0, 1'b0, ofs, 16'h0, 1'b0, e, tag);
    endtask

    task automatic unlock();
        lrd(3'd1, 1'b1);
        lrd(3'd1, 1'b1);
        lwr(3'd2, 8'h03);
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(!cfg_mode && !timing_override, "R1 locked, override off",
            {cfg_mode, timing_override}, 0);
        chk(rd_active == 8'hFF && rd_recover == 8'hFF && wr_active == 8'hFF
            && wr_recover == 8'hFF, "R1 default timing",
            {rd_active, rd_recover, wr_active, wr_recover}, 32'hFFFFFFFF);
        chk(addr_setup == 2'd3, "R1 default addr_setup", addr_setup, 3);

        // R2 / R11: locked traffic forwarded, internal state untouched
        acc(1'b1, 1'b1, 3'd0, 16'h1234, 1'b1, 16'h0, "");
        lwr(3'd0, 8'h42);
        lwr(3'd6, 8'h01);
        lrd(3'd7, 1'b0);
        lrd(3'd6, 1'b1);
        idle();
        chk(rd_active == 8'hFF && addr_setup == 2'd3 && !cfg_mode,
            "R11 locked writes ignored", {rd_active, addr_setup}, {8'hFF, 2'd3});

        // R4: broken patterns do not open
        lrd(3'd1, 1'b1); lwr(3'd7, 8'h00); lrd(3'd1, 1'b1); lwr(3'd2, 8'h03);
        idle();
        chk(!cfg_mode, "R4 interleaved access clears", cfg_mode, 0);
        lrd(3'd1, 1'b1); lrd(3'd1, 1'b1); lwr(3'd2, 8'h05); lwr(3'd2, 8'h03);
        idle();
        chk(!cfg_mode, "R4 wrong key clears", cfg_mode, 0);
        lrd(3'd1, 1'b1); lrd(3'd1, 1'b0); lwr(3'd2, 8'h03);
        idle();
        chk(!cfg_mode, "R4 byte read breaks pattern", cfg_mode, 0);

        // R3: three reads still count as two
        lrd(3'd1, 1'b1); lrd(3'd1, 1'b1); lrd(3'd1, 1'b1); lwr(3'd2, 8'h03);
        idle();
        chk(cfg_mode, "R3 three reads then key opens", cfg_mode, 1);
        cwr(3'd2, 8'h83);
        idle();
        chk(!cfg_mode, "R10 close key locks", cfg_mode, 0);

        // R3: idle gaps allowed
        lrd(3'd1, 1'b1); idle(); idle();
        lrd(3'd1, 1'b1); idle();
        lwr(3'd2, 8'h03); idle();
        chk(cfg_mode, "R3 gapped pattern opens", cfg_mode, 1);

        // R5 / R6 / R7: program device 1 then device 0
        acc(1'b0, 1'b1, 3'd7, 16'h0, 1'b0, 16'h0000, "R5 open read of unused offset");
        cwr(3'd6, 8'h01);
        cwr(3'd0, 8'h58);
        cwr(3'd1, 8'h44);
        crd(3'd0, 16'h0058, "R7 readback dev1 read timing");
        cwr(3'd6, 8'h20);
        crd(3'd6, 16'h0020, "R6 misc readback");
        idle();
        chk(rd_active[7:4] == 4'h5 && rd_recover[7:4] == 4'h8,
            "R7 dev1 read nibbles", {rd_active[7:4], rd_recover[7:4]}, 8'h58);
        chk(wr_active[7:4] == 4'h4 && wr_recover[7:4] == 4'h4,
            "R7 dev1 write nibbles", {wr_active[7:4], wr_recover[7:4]}, 8'h44);
        chk(rd_active[3:0] == 4'hF && wr_recover[3:0] == 4'hF,
            "R7 dev0 untouched", {rd_active[3:0], wr_recover[3:0]}, 8'hFF);
        chk(addr_setup == 2'd2, "R6 shared addr_setup", addr_setup, 2);

        cwr(3'd6, 8'h00);
        cwr(3'd0, 8'h6B);
        cwr(3'd1, 8'h56);
        cwr(3'd6, 8'h30);
        crd(3'd0, 16'h006B, "R7 readback dev0 read timing");
        crd(3'd1, 16'h0056, "R7 readback dev0 write timing");
        idle();
        chk(rd_active[3:0] == 4'h6 && rd_recover[3:0] == 4'hB &&
            wr_active[3:0] == 4'h5 && wr_recover[3:0] == 4'h6,
            "R7 dev0 nibbles",
            {rd_active[3:0], rd_recover[3:0], wr_active[3:0], wr_recover[3:0]}, 16'h6B56);
        chk(rd_active[7:4] == 4'h5, "R6 dev1 kept after select change",
            rd_active[7:4], 5);
        chk(addr_setup == 2'd3, "R6 addr_setup 3", addr_setup, 3);

        // R8 control
        cwr(3'd3, 8'h85);
        idle();
        chk(timing_override, "R8 override set", timing_override, 1);
        crd(3'd3, 16'h0085, "R8 control readback");
        cwr(3'd3, 8'h84);
        idle();
        chk(!timing_override, "R8 other value clears", timing_override, 0);
        cwr(3'd3, 8'h85);
        idle();

        // R9 strap probe
        clk_strap = 1'b1;
        crd(3'd5, 16'h0000, "R9 strap hidden before probe");
        cwr(3'd5, 8'hFF);
        crd(3'd5, 16'h0001, "R9 strap high");
        idle();
        clk_strap = 1'b0;
        crd(3'd5, 16'h0000, "R9 strap low");
        idle();
        clk_strap = 1'b1;
        cwr(3'd5, 8'h12);
        crd(3'd5, 16'h0000, "R9 other probe value hides strap");

        // R12 wide write ignored
        acc(1'b1, 1'b1, 3'd0, 16'h0011, 1'b0, 16'h0, "");
        acc(1'b1, 1'b1, 3'd3, 16'h0000, 1'b0, 16'h0, "");
        crd(3'd0, 16'h006B, "R12 wide write ignored");
        idle();
        chk(timing_override, "R12 wide control write ignored", timing_override, 1);

        // R10 other gate value keeps the window open
        cwr(3'd2, 8'h55);
        idle();
        chk(cfg_mode, "R10 other gate value ignored", cfg_mode, 1);
        cwr(3'd2, 8'h83);
        idle();
        chk(!cfg_mode, "R10 relocked", cfg_mode, 0);

        // R11 after relock
        lwr(3'd3, 8'h00);
        lwr(3'd0, 8'h99);
        lrd(3'd0, 1'b0);
        idle();
        chk(timing_override && rd_active[3:0] == 4'h6, "R11 state kept after relock",
            {timing_override, rd_active[3:0]}, {1'b1, 4'h6});

        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule